// File: doc/BRIEF.md
# Short Vector Register Iteration Sequencer

This block turns one floating-point register-to-register operation into a series of register-address triples, one for each iteration. Each triple names a destination, a first source and a second source. It is given the three register numbers of the operation, a precision select, a 3-bit length field, a 2-bit stride field, a flag that marks operations that can only run on scalars, and a two-operand flag. From these it decides whether the operation is scalar, vector-by-scalar or vector-by-vector. It then issues the triples to a downstream datapath with a valid/ready handshake and marks the final one.

The register space is split into banks. In single precision a bank holds 8 registers out of 32. In double precision a bank holds 4 registers out of 16. The lowest bank, bank 0, has a special role: a destination in bank 0 makes the operation scalar, and a second source in bank 0 is held fixed as a scalar operand. An index that steps forward stays inside its own bank and wraps to the start of that bank.

Top module: `vec_iter_seq`

## Requirements
- R1: A vector operation (vector-by-scalar or vector-by-vector) issues exactly len_i+1 triples. len_i is an unsigned 3-bit value, so 0 gives 1 triple and 7 gives 8.
- R2: stride_i = 2'b00 moves each stepping index by 1 per iteration. stride_i = 2'b11 moves it by 2.
- R3: Bank 0 is index < 8 in single precision (dbl_i=0) and index < 4 in double precision (dbl_i=1). kind_o reports 0 for scalar, 1 for vector-by-scalar and 2 for vector-by-vector.
- R4: The operation is scalar if scalar_only_i=1, or the destination is in bank 0, or len_i=0. A scalar operation issues exactly one triple, equal to the captured register numbers.
- R5: If the operation is not scalar and the second source is in bank 0, it is vector-by-scalar. srcm_o stays fixed while dst_o and srcn_o step.
- R6: If the operation is not scalar and the second source is outside bank 0, it is vector-by-vector. All three indices step.
- R7: A stepping index keeps its bank bits and wraps modulo the bank size, 8 in single precision and 4 in double precision.
- R8: When two_op_i=1, srcn_o reads 0 on every triple and does not step. The classification is unchanged.
- R9: While valid_o=1 and ready_i=0, the triple, kind_o and last_o hold their values.
- R10: busy_o (equal to valid_o) rises the cycle after an accepted start and falls the cycle after the final triple is accepted. A start_i pulse while busy_o=1 is ignored.
- R11: If start_i arrives while idle with stride_i = 2'b01 or 2'b10, err_o goes high for exactly one cycle and no triple is issued.
- R12: last_o is high only on the final triple of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe for a new operation |
| dst_i | input | 5 | Destination register number |
| srcn_i | input | 5 | First source register number |
| srcm_i | input | 5 | Second source register number |
| dbl_i | input | 1 | 1 = double precision, 0 = single precision |
| two_op_i | input | 1 | Operation has only one source (the second) |
| scalar_only_i | input | 1 | Operation class that always runs as a scalar |
| len_i | input | 3 | Length field; iterations = value + 1 |
| stride_i | input | 2 | Stride field: 00 step 1, 11 step 2, others reserved |
| ready_i | input | 1 | Downstream accepts the current triple |
| valid_o | output | 1 | A triple is presented |
| dst_o | output | 5 | Destination index for this iteration |
| srcn_o | output | 5 | First source index for this iteration |
| srcm_o | output | 5 | Second source index for this iteration |
| last_o | output | 1 | Final triple of the operation |
| kind_o | output | 2 | 0 scalar, 1 vector-by-scalar, 2 vector-by-vector |
| busy_o | output | 1 | Operation in progress |
| err_o | output | 1 | One-cycle pulse on a reserved stride |

## Verification
The bench uses the default parameters: 5-bit indices, banks of 8 and 4 registers, and a 3-bit length field. This configuration is small enough to sweep every destination index in both precisions, every length value and both legal strides. The sweep uses second sources that fall both inside and outside bank 0, so every classification is exercised and every wrap point inside a bank is crossed. A repeating ready pattern that stalls one cycle in three checks the hold behaviour during vector runs. A spurious start is injected during every operation to confirm it is ignored.

// File: rtl/vis_pkg.sv
package vis_pkg;
    typedef enum logic [1:0] {
        OP_SCALAR  = 2'd0,
        OP_VEC_SCL = 2'd1,
        OP_VEC_VEC = 2'd2
    } op_kind_e;
endpackage

// File: rtl/vis_classify.sv
module vis_classify
    import vis_pkg::*;
#(
    parameter int IDX_W   = 5,
    parameter int LEN_W   = 3,
    parameter int SP_BANK = 8,
    parameter int DP_BANK = 4
) (
    input  logic [IDX_W-1:0] dst_i,
    input  logic [IDX_W-1:0] srcm_i,
    input  logic             dbl_i,
    input  logic             scalar_only_i,
    input  logic [LEN_W-1:0] len_i,
    output op_kind_e         kind_o,
    output logic [LEN_W-1:0] left_o
);
    logic [IDX_W-1:0] bank_lim;
    logic             dst_b0;
    logic             m_b0;

    always_comb begin
        bank_lim = dbl_i ? IDX_W'(DP_BANK) : IDX_W'(SP_BANK);
        dst_b0   = (dst_i < bank_lim);
        m_b0     = (srcm_i < bank_lim);
        if (scalar_only_i || dst_b0 || (len_i == '0)) begin
            kind_o = OP_SCALAR;
        end else if (m_b0) begin
            kind_o = OP_VEC_SCL;
        end else begin
            kind_o = OP_VEC_VEC;
        end
        left_o = (kind_o == OP_SCALAR) ? '0 : len_i;
    end
endmodule

// File: rtl/vis_step.sv
module vis_step #(
    parameter int IDX_W   = 5,
    parameter int SP_BANK = 8,
    parameter int DP_BANK = 4
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [1:0]       step_i,
    input  logic             dbl_i,
    input  logic             en_i,
    output logic [IDX_W-1:0] next_o
);
    logic [IDX_W-1:0] lo_mask;
    logic [IDX_W-1:0] sum;

    always_comb begin
        lo_mask = dbl_i ? IDX_W'(DP_BANK - 1) : IDX_W'(SP_BANK - 1);
        sum     = idx_i + IDX_W'(step_i);
        next_o  = en_i ? ((idx_i & ~lo_mask) | (sum & lo_mask)) : idx_i;
    end
endmodule

// File: rtl/vec_iter_seq.sv
module vec_iter_seq
    import vis_pkg::*;
#(
    parameter int IDX_W   = 5,
    parameter int LEN_W   = 3,
    parameter int SP_BANK = 8,
    parameter int DP_BANK = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IDX_W-1:0] dst_i,
    input  logic [IDX_W-1:0] srcn_i,
    input  logic [IDX_W-1:0] srcm_i,
    input  logic             dbl_i,
    input  logic             two_op_i,
    input  logic             scalar_only_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [1:0]       stride_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] dst_o,
    output logic [IDX_W-1:0] srcn_o,
    output logic [IDX_W-1:0] srcm_o,
    output logic             last_o,
    output logic [1:0]       kind_o,
    output logic             busy_o,
    output logic             err_o
);
    localparam int SP_LOG = $clog2(SP_BANK);
    localparam int DP_LOG = $clog2(DP_BANK);
    localparam int N_IDX  = 3;

    typedef struct packed {
        logic             busy;
        logic             err;
        logic             dbl;
        logic             two;
        op_kind_e         kind;
        logic [LEN_W-1:0] left;
        logic [1:0]       step;
        logic [IDX_W-1:0] d;
        logic [IDX_W-1:0] n;
        logic [IDX_W-1:0] m;
    } seq_st_t;

    seq_st_t st_d, st_q;

    op_kind_e         cls_kind;
    logic [LEN_W-1:0] cls_left;
    logic             issue;
    logic             stride_bad;

    logic [IDX_W-1:0] idx_cur [N_IDX];
    logic [IDX_W-1:0] idx_nxt [N_IDX];
    logic             idx_en  [N_IDX];

    vis_classify #(
        .IDX_W  (IDX_W),
        .LEN_W  (LEN_W),
        .SP_BANK(SP_BANK),
        .DP_BANK(DP_BANK)
    ) u_cls (
        .dst_i        (dst_i),
        .srcm_i       (srcm_i),
        .dbl_i        (dbl_i),
        .scalar_only_i(scalar_only_i),
        .len_i        (len_i),
        .kind_o       (cls_kind),
        .left_o       (cls_left)
    );

    always_comb begin
        idx_cur[0] = st_q.d;
        idx_cur[1] = st_q.n;
        idx_cur[2] = st_q.m;
        idx_en[0]  = (st_q.kind != OP_SCALAR);
        idx_en[1]  = (st_q.kind != OP_SCALAR) && !st_q.two;
        idx_en[2]  = (st_q.kind == OP_VEC_VEC);
    end

    for (genvar g = 0; g < N_IDX; g++) begin : g_step
        vis_step #(
            .IDX_W  (IDX_W),
            .SP_BANK(SP_BANK),
            .DP_BANK(DP_BANK)
        ) u_step (
            .idx_i (idx_cur[g]),
            .step_i(st_q.step),
            .dbl_i (st_q.dbl),
            .en_i  (idx_en[g]),
            .next_o(idx_nxt[g])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.err   = 1'b0;
        issue      = st_q.busy && ready_i;
        stride_bad = (stride_i == 2'b01) || (stride_i == 2'b10);
        if (issue) begin
            if (st_q.left == '0) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.left = st_q.left - 1'b1;
                st_d.d    = idx_nxt[0];
                st_d.n    = idx_nxt[1];
                st_d.m    = idx_nxt[2];
            end
        end else if (!st_q.busy && start_i) begin
            if (stride_bad) begin
                st_d.err = 1'b1;
            end else begin
                st_d.busy = 1'b1;
                st_d.dbl  = dbl_i;
                st_d.two  = two_op_i;
                st_d.kind = cls_kind;
                st_d.left = cls_left;
                st_d.step = (stride_i == 2'b11) ? 2'd2 : 2'd1;
                st_d.d    = dst_i;
                st_d.n    = two_op_i ? '0 : srcn_i;
                st_d.m    = srcm_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        valid_o = st_q.busy;
        busy_o  = st_q.busy;
        err_o   = st_q.err;
        dst_o   = st_q.d;
        srcn_o  = st_q.n;
        srcm_o  = st_q.m;
        kind_o  = st_q.kind;
        last_o  = st_q.busy && (st_q.left == '0);
    end

    logic [IDX_W-1:0] d_bank;
    assign d_bank = st_q.dbl ? (st_q.d >> DP_LOG) : (st_q.d >> SP_LOG);

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !ready_i |=> valid_o && $stable(dst_o) && $stable(srcn_o) && $stable(srcm_o) && $stable(last_o)) else $error("hold"); // R9
    AST_SCALAR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && (kind_o == 2'd0) |-> last_o) else $error("scalar"); // R4
    AST_SCALAR_OPND_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && ready_i && !last_o && (kind_o == 2'd1) |=> $stable(srcm_o)) else $error("vs m"); // R5
    AST_BANK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && ready_i && !last_o |=> $stable(d_bank)) else $error("bank"); // R7
    AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && ready_i && last_o |=> !busy_o) else $error("busy"); // R10
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !valid_o) else $error("err"); // R11
endmodule

// File: tb/sim_vec_iter_seq.sv
module sim_vec_iter_seq;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i, dbl_i, two_op_i, scalar_only_i, ready_i;
    logic [4:0] dst_i, srcn_i, srcm_i;
    logic [2:0] len_i;
    logic [1:0] stride_i;
    logic       valid_o, last_o, busy_o, err_o;
    logic [4:0] dst_o, srcn_o, srcm_o;
    logic [1:0] kind_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rcnt = 0;
    bit done = 0;

    always #4 clk = ~clk;

    vec_iter_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dst_i(dst_i),
        .srcn_i(srcn_i), .srcm_i(srcm_i), .dbl_i(dbl_i), .two_op_i(two_op_i),
        .scalar_only_i(scalar_only_i), .len_i(len_i), .stride_i(stride_i),
        .ready_i(ready_i), .valid_o(valid_o), .dst_o(dst_o), .srcn_o(srcn_o),
        .srcm_o(srcm_o), .last_o(last_o), .kind_o(kind_o), .busy_o(busy_o),
        .err_o(err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 190000);
            finish_run();
        end
    end

    function automatic int wrapi(int base, int k, int step, int bsz);
        return (base / bsz) * bsz + ((base % bsz + k * step) % bsz);
    endfunction

    task automatic run_op(input int dbl, input int dst, input int n, input int m,
                          input int len, input int stride, input int so, input int two);
        int bsz, kind, cnt, step, ed, en, em, i, guard, pd, pn, pm;
        bit rdy, prev_rdy, spur;
        string tg;
        bsz  = dbl ? 4 : 8;
        kind = (so != 0 || dst < bsz || len == 0) ? 0 : (m < bsz ? 1 : 2);
        cnt  = (kind == 0) ? 1 : len + 1;
        step = (stride == 3) ? 2 : 1;
        tg   = (kind == 0) ? "R4" : (kind == 1 ? "R5" : "R6");
        @(negedge clk);
        start_i = 1; dst_i = 5'(dst); srcn_i = 5'(n); srcm_i = 5'(m);
        dbl_i = 1'(dbl); len_i = 3'(len); stride_i = 2'(stride);
        scalar_only_i = 1'(so); two_op_i = 1'(two); ready_i = 0;
        @(negedge clk);
        i = 0; guard = 0; spur = 1; prev_rdy = 1; pd = 0; pn = 0; pm = 0;
        while (i < cnt && guard < 40) begin
            rdy = (rcnt % 3) != 2;
            rcnt++;
            ed = (kind == 0) ? dst : wrapi(dst, i, step, bsz);
            en = (two != 0) ? 0 : ((kind == 0) ? n : wrapi(n, i, step, bsz));
            em = (kind == 2) ? wrapi(m, i, step, bsz) : m;
            chk(valid_o === 1'b1, "R10 valid during run", int'(valid_o), 1);
            chk(kind_o == 2'(kind), "R3 kind", int'(kind_o), kind);
            chk(dst_o == 5'(ed), (stride == 3) ? "R2 dst step" : tg, int'(dst_o), ed);
            chk(srcn_o == 5'(en), (two != 0) ? "R8 srcn" : tg, int'(srcn_o), en);
            chk(srcm_o == 5'(em), tg, int'(srcm_o), em);
            chk(int'(dst_o) / bsz == dst / bsz, "R7 bank kept", int'(dst_o) / bsz, dst / bsz);
            chk(last_o == (i == cnt - 1), "R12 last", int'(last_o), int'(i == cnt - 1));
            if (!prev_rdy)
                chk(dst_o == 5'(pd) && srcn_o == 5'(pn) && srcm_o == 5'(pm), "R9 hold",
                    int'(dst_o), pd);
            pd = int'(dst_o); pn = int'(srcn_o); pm = int'(srcm_o);
            prev_rdy = rdy;
            ready_i = rdy;
            start_i = spur;
            if (spur) begin
                dst_i = 5'(dst + 3); srcm_i = 5'(m + 1); len_i = 3'(len + 1);
            end
            spur = 0;
            @(negedge clk);
            start_i = 0;
            if (rdy) i++;
            guard++;
        end
        ready_i = 0;
        chk(i == cnt, "R1 count", i, cnt);
        chk(busy_o == 1'b0, "R1 no extra triple", int'(busy_o), 0);
        chk(valid_o == 1'b0, "R10 idle after last", int'(valid_o), 0);
    endtask

    task automatic run_err(input int stride);
        @(negedge clk);
        start_i = 1; stride_i = 2'(stride); dst_i = 5'd20; srcm_i = 5'd20;
        len_i = 3'd3; dbl_i = 0; scalar_only_i = 0; two_op_i = 0;
        @(negedge clk);
        start_i = 0;
        chk(err_o == 1'b1, "R11 err pulse", int'(err_o), 1);
        chk(busy_o == 1'b0, "R11 no issue", int'(busy_o), 0);
        @(negedge clk);
        chk(err_o == 1'b0, "R11 err one cycle", int'(err_o), 0);
        chk(valid_o == 1'b0, "R11 still idle", int'(valid_o), 0);
        stride_i = 0;
    endtask

    initial begin
        rst_n = 0; start_i = 0; dst_i = 0; srcn_i = 0; srcm_i = 0; dbl_i = 0;
        two_op_i = 0; scalar_only_i = 0; len_i = 0; stride_i = 0; ready_i = 0;
        repeat (3) @(negedge clk);
        chk(valid_o == 1'b0 && busy_o == 1'b0, "R10 reset idle", int'(busy_o), 0);
        chk(err_o == 1'b0, "R11 reset err", int'(err_o), 0);
        rst_n = 1;
        @(negedge clk);
        run_err(1);
        run_err(2);
        for (int dbl = 0; dbl < 2; dbl++) begin
            for (int dst = 0; dst < (dbl ? 16 : 32); dst++) begin
                for (int mi = 0; mi < 4; mi++) begin
                    for (int len = 0; len < 8; len++) begin
                        for (int s = 0; s < 2; s++) begin
                            int m, n, so, two;
                            if (dbl != 0) m = (mi == 0) ? 1 : (mi == 1 ? 3 : (mi == 2 ? 6 : 15));
                            else          m = (mi == 0) ? 0 : (mi == 1 ? 5 : (mi == 2 ? 9 : 30));
                            n   = (dst * 3 + len) % (dbl ? 16 : 32);
                            so  = ((dst + len) % 7 == 0) ? 1 : 0;
                            two = (dst % 5 == 0) ? 1 : 0;
                            run_op(dbl, dst, n, m, len, s ? 3 : 0, so, two);
                        end
                    end
                end
            end
        end
        run_err(2);
        finish_run();
    end
endmodule